// File: doc/BRIEF.md
# Reset Merge and Startup Delay Sequencer

This block combines four reset requests into a single active-low core reset and decides how long the core is held after the last request goes away. Two of the requests are cold: the power-on request and the external reset pin. A cold request stops the oscillator. Once the request is gone, the block waits for the supply to be reported good. It then enables the oscillator and counts a fixed settling interval of `2^BASE_LOG2` clocks. The default is 4096 clocks, about 410 µs at 10 MHz.

When the clock-mode option selects the internal clock, the core is released right after that interval. Any other clock-mode value adds a second interval of `(wake_opt + 1) * 2^BASE_LOG2` clocks before release. The other two requests, watchdog and low-voltage, are warm. A warm request never stops the oscillator, and the core is released as soon as the warm request drops.

Reset assertion is asynchronous. Release always passes through a two-flop synchroniser. A cause register shows which requests were active at the last reset.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While any of the four requests is active (`por_n` low, `ext_rst_n` low, `wdg_req` high, `lvd_req` high), `core_rst_n` is low, and it goes low without waiting for a clock edge.
- R2: A cold request (`por_n` or `ext_rst_n` low) drives `osc_en` low at once. After the request ends, `osc_en` and `core_rst_n` stay low for as long as `supply_ok` is low.
- R3: The first clock edge that finds `supply_ok` high with no request active sets `osc_en` high. From that edge, the settling interval lasts `2^BASE_LOG2` edges.
- R4: With `clk_mode` equal to 2'b00 (internal clock), `core_rst_n` is high after the `(2^BASE_LOG2 + 3)`-th edge, counting from the edge that first found `supply_ok` high.
- R5: With any other `clk_mode` value (2'b01, 2'b10 or 2'b11), release comes `(wake_opt + 1) * 2^BASE_LOG2` edges later than in R4. `wake_opt` is an 8-bit unsigned value, sampled when the first interval ends.
- R6: A warm request (`wdg_req` or `lvd_req`) leaves `osc_en` high. When no delay is in progress, `core_rst_n` is high after the second edge after the request drops.
- R7: `rst_cause` bits are: bit0 power-on, bit1 external pin, bit2 watchdog, bit3 low-voltage. `por_n` low sets the register to 4'b0001 at once. At every other edge where a request is active, the register loads the set of active requests. The value is held while no request is active.
- R8: A new cold request during a delay restarts the sequence from the supply wait. A warm request during a delay reloads the first interval, so the core is high after the `(2^BASE_LOG2 + 2)`-th edge after the warm request drops (internal clock).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sequencer clock |
| por_n | input | 1 | Power-on reset request, active low |
| ext_rst_n | input | 1 | External reset pin, active low |
| wdg_req | input | 1 | Watchdog reset request, active high |
| lvd_req | input | 1 | Low-voltage detector reset request, active high |
| supply_ok | input | 1 | Internal supply has reached nominal level |
| clk_mode | input | 2 | Clock source option; 2'b00 selects the internal clock |
| wake_opt | input | OPT_W | Prescaler for the second startup interval |
| osc_en | output | 1 | Oscillator enable |
| core_rst_n | output | 1 | Core reset, active low |
| rst_cause | output | 4 | Sources active at the last reset |

## Verification
Each result has its own timing. Assertion of `core_rst_n` and the drop of `osc_en` are checked one time unit after the request changes, with no clock edge in between. `osc_en` is due on the edge that finds the supply good. Warm release is due two edges after the request drops, cold release with the internal clock `2^BASE_LOG2 + 3` edges after the supply edge, and external-clock release a further `(wake_opt + 1) * 2^BASE_LOG2` edges on. The bench drives inputs only on falling edges. After every rising edge it compares all outputs against a behavioural model stepped by that edge. Release latency is also measured on its own by counting edges until `core_rst_n` is seen high, and compared with the formula.

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int         BASE_LOG2 = 12,
  parameter int         OPT_W     = 8,
  parameter logic [1:0] INT_MODE  = 2'b00
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             ext_rst_n,
  input  logic             wdg_req,
  input  logic             lvd_req,
  input  logic             supply_ok,
  input  logic [1:0]       clk_mode,
  input  logic [OPT_W-1:0] wake_opt,
  output logic             osc_en,
  output logic             core_rst_n,
  output logic [3:0]       rst_cause
);

  localparam int CNT_W = OPT_W + BASE_LOG2 + 1;
  localparam logic [CNT_W-1:0] BASE_LAST = CNT_W'((1 << BASE_LOG2) - 1);

  typedef enum logic [1:0] {S_WAIT, S_BASE, S_EXT, S_RUN} st_t;

  st_t              state;
  logic [CNT_W-1:0] cnt;
  logic [1:0]       sync_q;

  wire cold    = ~por_n | ~ext_rst_n;
  wire warm    = wdg_req | lvd_req;
  wire arst    = cold | warm;
  wire ext_clk = clk_mode != INT_MODE;
  wire release_ok = (state == S_RUN) && !warm;
  wire [CNT_W-1:0] ext_last = ((CNT_W'(wake_opt) + CNT_W'(1)) << BASE_LOG2) - CNT_W'(1);

  always_ff @(posedge clk or posedge cold) begin
    if (cold) begin
      state <= S_WAIT;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_WAIT: if (supply_ok) begin
          state <= S_BASE;
          cnt   <= BASE_LAST;
        end
        S_BASE, S_EXT: begin
          if (warm) begin
            state <= S_BASE;
            cnt   <= BASE_LAST;
          end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
          end else if (state == S_BASE && ext_clk) begin
            state <= S_EXT;
            cnt   <= ext_last;
          end else begin
            state <= S_RUN;
          end
        end
        S_RUN: cnt <= '0;
        default: state <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or posedge arst) begin
    if (arst) sync_q <= 2'b00;
    else      sync_q <= {sync_q[0], release_ok};
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)    rst_cause <= 4'b0001;
    else if (arst) rst_cause <= {lvd_req, wdg_req, ~ext_rst_n, 1'b0};
  end

  assign osc_en     = state != S_WAIT;
  assign core_rst_n = sync_q[1];

  assert_req_holds_core_R1: assert property (@(posedge clk)
    (cold | warm) |-> !core_rst_n);

  assert_cold_stops_osc_R2: assert property (@(posedge clk)
    cold |-> !osc_en);

  assert_wait_supply_R2: assert property (@(posedge clk) disable iff (cold)
    (!osc_en && !supply_ok) |=> !osc_en);

  assert_run_keeps_zero_R3: assert property (@(posedge clk) disable iff (arst)
    (state == S_RUN) |=> (cnt == '0));

  assert_release_via_sync_R6: assert property (@(posedge clk) disable iff (arst)
    $rose(core_rst_n) |-> $past(sync_q[0]));

  assert_cause_hold_R7: assert property (@(posedge clk) disable iff (arst)
    !$past(arst) |-> $stable(rst_cause));

endmodule

// File: tb/rst_seq_ctrl_tb.sv
`timescale 1ns/1ps
module rst_seq_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int LOG2  = 3;
  localparam int B     = 1 << LOG2;

  logic clk = 0;
  logic por_n = 0, ext_rst_n = 1, wdg_req = 0, lvd_req = 0, supply_ok = 0;
  logic [1:0] clk_mode = 2'b00;
  logic [7:0] wake_opt = 8'd0;
  logic osc_en, core_rst_n;
  logic [3:0] rst_cause;

  int tests = 0, fails = 0;
  string tag = "R7";

  // reference model state
  int m_ph = 0, m_cnt = 0;
  bit m_s0 = 0, m_s1 = 0;
  logic [3:0] m_cause = 4'b0001;

  rst_seq_ctrl #(.BASE_LOG2(LOG2), .OPT_W(8)) u_dut (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdg_req(wdg_req),
    .lvd_req(lvd_req), .supply_ok(supply_ok), .clk_mode(clk_mode),
    .wake_opt(wake_opt), .osc_en(osc_en), .core_rst_n(core_rst_n),
    .rst_cause(rst_cause));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(string t, string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  task automatic compare_model();
    check(tag, "osc_en", osc_en, (m_ph != 0));
    check(tag, "core_rst_n", core_rst_n, m_s1);
    check(tag, "rst_cause", rst_cause, m_cause);
  endtask

  task automatic model_async();
    if (!por_n || !ext_rst_n) begin m_ph = 0; m_cnt = 0; m_s0 = 0; m_s1 = 0; end
    if (wdg_req || lvd_req) begin m_s0 = 0; m_s1 = 0; end
    if (!por_n) m_cause = 4'b0001;
  endtask

  always @(posedge clk) begin
    bit cold, warm, rel;
    #(CLK_P/4);
    cold = !por_n || !ext_rst_n;
    warm = wdg_req || lvd_req;
    rel  = (m_ph == 3) && !warm;
    if (cold) begin
      m_ph = 0; m_cnt = 0; m_s0 = 0; m_s1 = 0;
    end else begin
      if (warm) begin m_s0 = 0; m_s1 = 0; end
      else begin m_s1 = m_s0; m_s0 = rel; end
      case (m_ph)
        0: if (supply_ok) begin m_ph = 1; m_cnt = B - 1; end
        1, 2: begin
          if (warm) begin m_ph = 1; m_cnt = B - 1; end
          else if (m_cnt > 0) m_cnt--;
          else if (m_ph == 1 && clk_mode != 2'b00) begin m_ph = 2; m_cnt = (wake_opt + 1) * B - 1; end
          else m_ph = 3;
        end
        default: ;
      endcase
    end
    if (!por_n) m_cause = 4'b0001;
    else if (cold || warm) m_cause = {lvd_req, wdg_req, !ext_rst_n, 1'b0};
    compare_model();
  end

  task automatic drive(logic p, logic e, logic w, logic l, logic s);
    @(negedge clk);
    por_n = p; ext_rst_n = e; wdg_req = w; lvd_req = l; supply_ok = s;
    #1;
    model_async();
    compare_model();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic edges_to_release(output int n);
    n = 0;
    while (n < 5000) begin
      @(posedge clk);
      #(CLK_P/2 - 1);
      n++;
      if (core_rst_n) break;
    end
  endtask

  task automatic ext_pulse();
    drive(1, 0, 0, 0, 1);
    check("R1", "core_rst_n async", core_rst_n, 0);
    check("R2", "osc_en async", osc_en, 0);
    idle(2);
    drive(1, 1, 0, 0, 1);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    int n;
    idle(3);
    check("R7", "cause at por", rst_cause, 4'b0001);
    check("R2", "osc_en at por", osc_en, 0);
    check("R1", "core at por", core_rst_n, 0);

    tag = "R2";
    drive(1, 1, 0, 0, 0);
    idle(6);
    check("R2", "osc_en without supply", osc_en, 0);
    check("R2", "core without supply", core_rst_n, 0);

    tag = "R4";
    drive(1, 1, 0, 0, 1);
    edges_to_release(n);
    check("R4", "internal-clock release edges", n, B + 3);
    check("R3", "osc_en after supply", osc_en, 1);

    tag = "R6";
    drive(1, 1, 1, 0, 1);
    check("R1", "core on watchdog", core_rst_n, 0);
    check("R6", "osc kept on watchdog", osc_en, 1);
    drive(1, 1, 0, 0, 1);
    edges_to_release(n);
    check("R6", "watchdog release edges", n, 2);
    check("R7", "cause watchdog", rst_cause, 4'b0100);

    drive(1, 1, 0, 1, 1);
    check("R1", "core on low-voltage", core_rst_n, 0);
    drive(1, 1, 0, 0, 1);
    edges_to_release(n);
    check("R6", "low-voltage release edges", n, 2);
    check("R7", "cause low-voltage", rst_cause, 4'b1000);
    check("R6", "osc after low-voltage", osc_en, 1);

    tag = "R5";
    clk_mode = 2'b01; wake_opt = 8'd2;
    ext_pulse();
    edges_to_release(n);
    check("R5", "external-clock wake=2 edges", n, 4 * B + 3);
    check("R7", "cause external", rst_cause, 4'b0010);

    clk_mode = 2'b11; wake_opt = 8'd0;
    ext_pulse();
    edges_to_release(n);
    check("R5", "external-clock wake=0 edges", n, 2 * B + 3);

    tag = "R8";
    clk_mode = 2'b00;
    ext_pulse();
    idle(4);
    ext_pulse();
    edges_to_release(n);
    check("R8", "cold restart edges", n, B + 3);

    ext_pulse();
    idle(3);
    drive(1, 1, 1, 0, 1);
    check("R8", "osc kept during delay", osc_en, 1);
    drive(1, 1, 0, 0, 1);
    edges_to_release(n);
    check("R8", "warm reload edges", n, B + 2);
    check("R7", "cause after reload", rst_cause, 4'b0100);

    tag = "R5";
    clk_mode = 2'b10; wake_opt = 8'd255;
    ext_pulse();
    edges_to_release(n);
    check("R5", "external-clock wake=255 edges", n, 257 * B + 3);

    tag = "R7";
    idle(5);
    check("R7", "cause held", rst_cause, 4'b0010);
    drive(0, 1, 0, 0, 1);
    check("R7", "cause on power-on", rst_cause, 4'b0001);
    check("R2", "osc off on power-on", osc_en, 0);
    drive(1, 1, 0, 0, 1);
    clk_mode = 2'b00;
    edges_to_release(n);
    check("R4", "power-on release edges", n, B + 3);
    idle(2);
    report();
  end
endmodule